// File: doc/BRIEF.md
# Serial Port Baud and Shift Clock Generator

This block makes the timing enables for a serial port's transmitter and receiver. A down-counter running on the system clock divides by a programmable 12-bit divisor plus one and gives out a base tick. The receiver takes that base tick as it is. The transmitter takes a slower rate, set by the operating mode: one tick in 16 for normal asynchronous use, one in 8 at double speed, and one in 2 when the port is a synchronous master.

In synchronous mode a direction input decides where the shift clock comes from. As master, the block drives a square wave on the clock pin that toggles on every base tick. As slave, it brings the external clock pin into the system domain through a two-stage synchronizer. An edge detector then turns that clock's edges into transmit and receive enables, and a polarity input picks which edge belongs to which side. Every output is a one-cycle enable pulse in the system clock domain. No derived clock leaves the block.

Top module: `usart_clkgen`

## Requirements
- R1: While `rst` is high, `tx_tick`, `rx_tick` and `ck_out` read 0 one clock after it is sampled. Reset clears the divisor and the counter, so with no divisor written the first `rx_tick` appears one cycle after reset is released.
- R2: Outside slave mode, `rx_tick` pulses once every D+1 system clocks, where D is the 12-bit divisor {high nibble, low byte}.
- R3: A `wr_lo` write reloads the counter at once with {current high nibble, `wr_data`}. The first `rx_tick` after the write edge then appears D+1 clocks after that edge, whatever the counter held before.
- R4: A `wr_hi` write (`wr_data[3:0]` becomes the high nibble) does not disturb the count in progress. The period running at the time ends with its old length, and the new divisor applies from the next reload.
- R5: In asynchronous mode (`sync_en`=0) with `dbl_speed`=0, `tx_tick` pulses once every 16 base ticks, and each `tx_tick` falls in a cycle where `rx_tick` is also high.
- R6: In asynchronous mode with `dbl_speed`=1, `tx_tick` pulses once every 8 base ticks.
- R7: As synchronous master (`sync_en`=1, `ck_dir_out`=1), `tx_tick` pulses once every 2 base ticks whatever `dbl_speed` is, and `ck_out` changes level in exactly the cycles where `rx_tick` is high.
- R8: When the block is not a synchronous master, `ck_out` stays 0. In asynchronous mode, activity on `ck_in` has no effect on `tx_tick` or `rx_tick`.
- R9: As synchronous slave (`sync_en`=1, `ck_dir_out`=0) with `ck_pol`=0, each rising edge of `ck_in` gives exactly one `tx_tick` and each falling edge gives exactly one `rx_tick`. The pulse appears in the third system clock edge after the change, and the baud counter has no effect.
- R10: As synchronous slave with `ck_pol`=1, the roles swap: a rising `ck_in` edge gives one `rx_tick` and a falling edge gives one `tx_tick`, with the same three-edge latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_lo | input | 1 | Write strobe for the divisor low byte; forces a counter reload |
| wr_hi | input | 1 | Write strobe for the divisor high nibble |
| wr_data | input | 8 | Write data for both divisor parts |
| sync_en | input | 1 | 1 selects synchronous mode, 0 asynchronous |
| dbl_speed | input | 1 | Asynchronous double-speed select |
| ck_dir_out | input | 1 | Clock pin direction in synchronous mode: 1 master, 0 slave |
| ck_pol | input | 1 | Slave edge assignment: 0 means rising edge gives transmit |
| ck_in | input | 1 | External clock pin input |
| tx_tick | output | 1 | Transmit enable pulse |
| rx_tick | output | 1 | Receive base enable pulse |
| ck_out | output | 1 | Master clock pin output |

## Verification
The bench sweeps several divisors, including zero, across asynchronous normal, double-speed and master modes. It checks the first tick after a low-byte write and the spacing of the ticks that follow, so a counter that missed the forced reload, or that counted D instead of D+1 cycles, shows the wrong distance. A high-nibble write in mid-count must leave the running period alone and stretch only the next one; a design that reloaded at once would cut the current interval short. In slave mode the bench counts enables per external edge while the baud counter runs at full rate, and it measures the three-edge latency under both polarities. A design that leaked base ticks into slave mode, or swapped the edges, would show counts or latencies that are off. Toggling `ck_in` during asynchronous runs shows whether the pin leaks into the tick timing there.

// File: rtl/usart_clk_pkg.sv
package usart_clk_pkg;

  typedef enum logic [1:0] {
    CK_ASYNC  = 2'd0,
    CK_MASTER = 2'd1,
    CK_SLAVE  = 2'd2
  } ck_mode_e;

  localparam int RATIO_NORMAL = 16;
  localparam int RATIO_DOUBLE = 8;
  localparam int RATIO_SYNC   = 2;

  function automatic ck_mode_e decode_mode(logic sync_en, logic dir_out);
    if (!sync_en)     return CK_ASYNC;
    else if (dir_out) return CK_MASTER;
    else              return CK_SLAVE;
  endfunction

  function automatic int tx_ratio(ck_mode_e mode, logic dbl);
    if (mode != CK_ASYNC) return RATIO_SYNC;
    else if (dbl)         return RATIO_DOUBLE;
    else                  return RATIO_NORMAL;
  endfunction

endpackage

// File: rtl/baud_downcounter.sv
module baud_downcounter #(
  parameter int DIV_W = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_lo,
  input  logic       wr_hi,
  input  logic [7:0] wr_data,
  output logic       tick
);
  localparam int HI_W = DIV_W - 8;

  logic [7:0]       div_lo;
  logic [HI_W-1:0]  div_hi;
  logic [DIV_W-1:0] cnt;

  // divisor storage; the high part only reaches the counter at a reload
  always_ff @(posedge clk) begin
    if (rst) begin
      div_lo <= '0;
      div_hi <= '0;
    end else begin
      if (wr_lo) div_lo <= wr_data;
      if (wr_hi) div_hi <= wr_data[HI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (wr_lo)
      cnt <= {div_hi, wr_data};
    else if (cnt == '0)
      cnt <= {div_hi, div_lo};
    else
      cnt <= cnt - 1'b1;
  end

  assign tick = (cnt == '0);

endmodule

// File: rtl/tx_rate_divider.sv
module tx_rate_divider
  import usart_clk_pkg::*;
#(
  parameter int PRE_W = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  ck_mode_e mode,
  input  logic     dbl_speed,
  input  logic     tick,
  output logic     fire
);
  logic [PRE_W-1:0] pre;
  logic [PRE_W:0]   ratio;
  logic             at_last;

  assign ratio   = (PRE_W+1)'(tx_ratio(mode, dbl_speed));
  // ">=" lets a mode change that shrinks the ratio wrap at once
  assign at_last = ({1'b0, pre} >= (ratio - 1'b1));
  assign fire    = tick && at_last && (mode != CK_SLAVE);

  always_ff @(posedge clk) begin
    if (rst || mode == CK_SLAVE)
      pre <= '0;
    else if (tick)
      pre <= at_last ? '0 : pre + 1'b1;
  end

endmodule

// File: rtl/ext_clk_sync.sv
module ext_clk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ck_in,
  output logic rise,
  output logic fall
);
  // stages 0..STAGES-1 synchronize, the last one holds the previous level
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], ck_in};
  end

  assign rise =  sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] &  sh[STAGES];

endmodule

// File: rtl/usart_clkgen.sv
module usart_clkgen
  import usart_clk_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int PRE_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_lo,
  input  logic       wr_hi,
  input  logic [7:0] wr_data,
  input  logic       sync_en,
  input  logic       dbl_speed,
  input  logic       ck_dir_out,
  input  logic       ck_pol,
  input  logic       ck_in,
  output logic       tx_tick,
  output logic       rx_tick,
  output logic       ck_out
);
  ck_mode_e mode;
  logic     baud_tick;
  logic     div_fire;
  logic     ext_rise;
  logic     ext_fall;
  logic     slave_tx;
  logic     slave_rx;

  assign mode = decode_mode(sync_en, ck_dir_out);

  baud_downcounter #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst     (rst),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .wr_data (wr_data),
    .tick    (baud_tick)
  );

  tx_rate_divider #(.PRE_W(PRE_W)) u_txdiv (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .dbl_speed (dbl_speed),
    .tick      (baud_tick),
    .fire      (div_fire)
  );

  ext_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .ck_in (ck_in),
    .rise  (ext_rise),
    .fall  (ext_fall)
  );

  assign slave_tx = ck_pol ? ext_fall : ext_rise;
  assign slave_rx = ck_pol ? ext_rise : ext_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_tick <= 1'b0;
      rx_tick <= 1'b0;
      ck_out  <= 1'b0;
    end else begin
      unique case (mode)
        CK_SLAVE: begin
          tx_tick <= slave_tx;
          rx_tick <= slave_rx;
          ck_out  <= 1'b0;
        end
        CK_MASTER: begin
          tx_tick <= div_fire;
          rx_tick <= baud_tick;
          ck_out  <= baud_tick ? ~ck_out : ck_out;
        end
        default: begin
          tx_tick <= div_fire;
          rx_tick <= baud_tick;
          ck_out  <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/usart_clkgen_chk.sv
module usart_clkgen_chk (
  input logic clk,
  input logic rst,
  input logic sync_en,
  input logic ck_dir_out,
  input logic tx_tick,
  input logic rx_tick,
  input logic ck_out
);
  logic is_master;
  logic is_slave;
  assign is_master = sync_en &&  ck_dir_out;
  assign is_slave  = sync_en && !ck_dir_out;

  // R1: one clock after reset is sampled, all enables are low
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!tx_tick && !rx_tick && !ck_out));

  // R5: outside slave mode a transmit enable lands on a base tick
  a_r5_tx_on_base: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(is_slave) && tx_tick) |-> rx_tick);

  // R7: master clock pin changes only together with a base tick
  a_r7_ckout_on_tick: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(is_master) && (ck_out != $past(ck_out))) |-> rx_tick);

  // R8: clock pin stays low unless master
  a_r8_ckout_idle: assert property (@(posedge clk) disable iff (rst)
    !is_master |=> !ck_out);

  // R9: in slave mode one external edge never yields both enables
  a_r9_slave_edges_apart: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(is_slave)) |-> !(tx_tick && rx_tick));

endmodule

bind usart_clkgen usart_clkgen_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .sync_en    (sync_en),
  .ck_dir_out (ck_dir_out),
  .tx_tick    (tx_tick),
  .rx_tick    (rx_tick),
  .ck_out     (ck_out)
);

// File: tb/tb_usart_clkgen.sv
module tb_usart_clkgen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_lo = 1'b0;
  logic       wr_hi = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       sync_en = 1'b0;
  logic       dbl_speed = 1'b0;
  logic       ck_dir_out = 1'b0;
  logic       ck_pol = 1'b0;
  logic       ck_drv = 1'b0;
  logic       tog_ck = 1'b0;
  logic       tog_en = 1'b0;
  logic       ck_in;
  logic       tx_tick, rx_tick, ck_out;

  assign ck_in = tog_en ? tog_ck : ck_drv;

  usart_clkgen dut (
    .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .sync_en(sync_en), .dbl_speed(dbl_speed), .ck_dir_out(ck_dir_out),
    .ck_pol(ck_pol), .ck_in(ck_in),
    .tx_tick(tx_tick), .rx_tick(rx_tick), .ck_out(ck_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;
  int tx_cnt = 0, rx_cnt = 0, ck_hi_cnt = 0, tx_alone = 0, both_cnt = 0;
  int wlast = 0;

  always @(negedge clk) begin
    if (tx_tick) tx_cnt++;
    if (rx_tick) rx_cnt++;
    if (ck_out) ck_hi_cnt++;
    if (tx_tick && !rx_tick) tx_alone++;
    if (tx_tick && rx_tick) both_cnt++;
    if (tog_en && (cyc % 3 == 0)) tog_ck <= ~tog_ck;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    tx_cnt = 0; rx_cnt = 0; ck_hi_cnt = 0; tx_alone = 0; both_cnt = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic write_div(input int d);
    @(negedge clk); wr_hi = 1'b1; wr_data = 8'((d >> 8) & 15);
    @(negedge clk); wr_hi = 1'b0; wr_lo = 1'b1; wr_data = 8'(d & 255);
    @(posedge clk); #1; wr_lo = 1'b0;
    wlast = cyc;
  endtask

  task automatic wait_rx(output int t);
    do @(negedge clk); while (!rx_tick);
    t = cyc;
  endtask

  task automatic wait_tx(output int t);
    do @(negedge clk); while (!tx_tick);
    t = cyc;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 200000);
    finish_run();
  end

  int dl [5] = '{0, 1, 2, 5, 13};

  initial begin
    int t0, t1, t2, t3;
    logic c_prev;
    // R1: reset state, then first tick right after release
    do_reset();
    @(negedge clk);
    chk(rx_tick == 1'b1, "R1", "first rx after reset", rx_tick, 1);

    sync_en = 1'b1; ck_dir_out = 1'b1;
    write_div(0);
    repeat (9) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!tx_tick && !rx_tick && !ck_out, "R1", "outputs in reset",
        {tx_tick, rx_tick, ck_out}, 0);
    rst = 1'b0;

    // sweep modes and divisors
    for (int m = 0; m < 3; m++) begin
      for (int k = 0; k < 5; k++) begin
        int d, ratio;
        d = dl[k];
        do_reset();
        sync_en    = (m == 2);
        ck_dir_out = (m == 2);
        dbl_speed  = (m != 0);
        tog_en     = (m != 2);
        ratio      = (m == 0) ? 16 : (m == 1) ? 8 : 2;
        write_div(d);
        clear_mon();
        do @(negedge clk); while (!(rx_tick && cyc > wlast));
        t0 = cyc;
        chk(t0 - wlast == d + 1, "R3", "first rx after low write", t0 - wlast, d + 1);
        c_prev = ck_out;
        for (int i = 0; i < 2; i++) begin
          wait_rx(t1);
          chk(t1 - t0 == d + 1, "R2", "rx spacing", t1 - t0, d + 1);
          if (m == 2) chk(ck_out != c_prev, "R7", "ck_out toggles on tick", ck_out, !c_prev);
          c_prev = ck_out;
          t0 = t1;
        end
        wait_tx(t1); wait_tx(t2); wait_tx(t3);
        chk(t2 - t1 == ratio * (d + 1),
            (m == 0) ? "R5" : (m == 1) ? "R6" : "R7", "tx spacing a", t2 - t1, ratio * (d + 1));
        chk(t3 - t2 == ratio * (d + 1),
            (m == 0) ? "R5" : (m == 1) ? "R6" : "R7", "tx spacing b", t3 - t2, ratio * (d + 1));
        chk(tx_alone == 0, "R5", "tx without rx", tx_alone, 0);
        if (m != 2) chk(ck_hi_cnt == 0, "R8", "ck_out high outside master", ck_hi_cnt, 0);
        tog_en = 1'b0;
      end
    end

    // R4: high nibble written mid-count applies only after the next reload
    do_reset();
    sync_en = 1'b0; ck_dir_out = 1'b0; dbl_speed = 1'b0;
    write_div(3);
    wait_rx(t0);
    wr_hi = 1'b1; wr_data = 8'h01;
    @(posedge clk); #1; wr_hi = 1'b0;
    wait_rx(t1);
    wait_rx(t2);
    chk(t1 - t0 == 4, "R4", "running period kept", t1 - t0, 4);
    chk(t2 - t1 == 260, "R4", "next period uses new high", t2 - t1, 260);

    // R9: slave, polarity 0
    ck_drv = 1'b0;
    do_reset();
    sync_en = 1'b1; ck_dir_out = 1'b0; ck_pol = 1'b0;
    repeat (4) @(negedge clk);
    clear_mon();
    @(negedge clk); ck_drv = 1'b1; t0 = cyc;
    wait_tx(t1);
    chk(t1 - t0 == 3, "R9", "rise to tx latency", t1 - t0, 3);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      ck_drv = 1'b0; repeat (4) @(negedge clk);
      ck_drv = 1'b1; repeat (4) @(negedge clk);
    end
    ck_drv = 1'b0; repeat (6) @(negedge clk);
    chk(tx_cnt == 6, "R9", "tx per rising edge", tx_cnt, 6);
    chk(rx_cnt == 6, "R9", "rx per falling edge", rx_cnt, 6);
    chk(ck_hi_cnt == 0, "R8", "ck_out low in slave", ck_hi_cnt, 0);
    chk(both_cnt == 0, "R9", "tx and rx together", both_cnt, 0);

    // R10: slave, polarity 1
    do_reset();
    ck_pol = 1'b1;
    repeat (4) @(negedge clk);
    clear_mon();
    @(negedge clk); ck_drv = 1'b1; t0 = cyc;
    wait_rx(t1);
    chk(t1 - t0 == 3, "R10", "rise to rx latency", t1 - t0, 3);
    chk(tx_cnt == 0, "R10", "no tx on rise", tx_cnt, 0);
    repeat (4) @(negedge clk);
    ck_drv = 1'b0; t0 = cyc;
    wait_tx(t2);
    chk(t2 - t0 == 3, "R10", "fall to tx latency", t2 - t0, 3);
    repeat (4) @(negedge clk);
    chk(rx_cnt == 1 && tx_cnt == 1, "R10", "one pulse per edge", rx_cnt + tx_cnt, 2);

    finish_run();
  end

endmodule